// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends characters one at a time over the single data line of an ISO 7816 style smart card link. A character is loaded into a holding buffer either by a processor write or by a DMA write. When transmission is enabled and the buffer holds data that has not yet been sent, the engine moves the byte into its shifter and drives the frame. The frame is a low start bit, eight data bits sent LSB first, and an even-parity bit. Bit timing comes from a counter that runs in half-bit steps. The half-bit length is a programmable number of system clock cycles.

Two status flags are kept. The empty flag reports that the holding buffer may be refilled. The end flag reports that the last character has fully left, including its guard time. The end flag is raised at a fixed fractional-bit point measured from the leading edge of the start bit. That point depends on the GSM-mode select: 12.5 bit times normally, 11.0 bit times in GSM mode. The flag is raised there only if the buffer is still empty and no error signal was seen. During the guard window, the block samples the line input to catch a card's error signal. It also produces the card clock. In GSM mode the clock can be held at a fixed high or low level, and otherwise it can only be switched on and off.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, tx_o is 1, tdre_o is 1, tend_o is 1, err_o is 0 and card_clk_o is 0.
- R2: A frame is sent as a start bit of 0, then data bits 0 through 7, then the XOR of the eight data bits (even parity). Each bit lasts 2*half_len_i cycles, and the line is 1 when no frame is active.
- R3: When tx_en_i=1, standby_i=0, tdre_o=0 and no frame is active, the next clock edge starts a frame from the buffer and sets tdre_o to 1. A frame can start on the cycle after the previous frame ends.
- R4: With gsm_i=0, tend_o becomes 1 exactly 25*half_len_i cycles after the start bit begins.
- R5: With gsm_i=1, tend_o becomes 1 exactly 22*half_len_i cycles after the start bit begins.
- R6: At that point, tend_o stays 0 if tdre_o is 0 or err_o is 1.
- R7: A tdre_clr_i pulse clears both tdre_o and tend_o only if tdre_rd_i was pulsed while tdre_o was 1. Without that read it has no effect.
- R8: A wr_dma_i pulse loads wr_data_i into the buffer and clears tdre_o and tend_o.
- R9: tend_o is forced to 1 on the next edge while tx_en_i=0 and err_o=0, or while standby_i=1. Either condition also abandons the active frame and returns tx_o to 1.
- R10: err_o is set when line_i is 0 at the edge that ends half-bit 20 of a frame (10.5 bit times in). Only err_clr_i clears it.
- R11: With gsm_i=0, ck_sel_i bit 0 alone decides the clock: 1 runs it and 0 holds card_clk_o at 0.
- R12: With gsm_i=1, ck_sel_i=00 holds card_clk_o low, 10 holds it high, and 01 or 11 run it.
- R13: A running card clock toggles every CK_HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby entry; forces the end flag and stops the frame |
| tx_en_i | input | 1 | Transmit enable |
| gsm_i | input | 1 | GSM-mode select |
| half_len_i | input | LEN_W | Half-bit length in system cycles (0 acts as 1) |
| wr_cpu_i | input | 1 | Processor write strobe for the holding buffer |
| wr_dma_i | input | 1 | DMA write strobe; loads the buffer and clears the flags |
| wr_data_i | input | DATA_W | Write data |
| tdre_rd_i | input | 1 | Processor read of the empty flag |
| tdre_clr_i | input | 1 | Processor write of 0 to the empty flag |
| err_clr_i | input | 1 | Clears the error flag |
| line_i | input | 1 | Data line as seen at the pin, for error sampling |
| ck_sel_i | input | 2 | Card clock control |
| tx_o | output | 1 | Serial data output |
| card_clk_o | output | 1 | Card clock output |
| tdre_o | output | 1 | Buffer empty flag |
| tend_o | output | 1 | Transmission end flag |
| err_o | output | 1 | Error signal flag |

## Verification
The bench times the rise of the end flag to the exact cycle in both modes. A design that counted whole bits, or measured from the last data bit, would raise it one half-bit off and fail the checks one cycle before and at the point. It also refills the buffer by DMA in the middle of a frame. A design that ignored the empty flag at the point would then report the end while a second character was queued, and one that started that character a cycle late would miss the back-to-back check. Other cases are a clear strobe with no preceding read, which must leave both flags alone, and an injected low line in the guard window, which must both raise the error and suppress the end flag. The fixed-level clock encodings are checked in each mode, so a design that honoured the high hold outside GSM mode is caught.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

   // card clock control encoding
   typedef enum logic [1:0] {
      CKS_LOW  = 2'b00,
      CKS_RUN  = 2'b01,
      CKS_HIGH = 2'b10,
      CKS_RSV  = 2'b11
   } cks_e;

   // number of bit slots in a frame: start + data + parity
   function automatic int frame_bits(input int data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int LEN_W = 12,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             run_i,
   input  logic [LEN_W-1:0] half_len_i,
   output logic [IDX_W-1:0] half_idx_o,
   output logic             half_end_o
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] last_w;
   logic [IDX_W-1:0] idx_q;

   // a zero length behaves as one cycle per half-bit
   assign last_w     = (half_len_i == '0) ? '0 : half_len_i - LEN_W'(1);
   assign half_end_o = run_i && !start_i && (cnt_q >= last_w);
   assign half_idx_o = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (start_i || !run_i) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (half_end_o) begin
         cnt_q <= '0;
         idx_q <= idx_q + IDX_W'(1);
      end else begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   // R4
   half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !start_i && !half_end_o) |=> $stable(half_idx_o));

endmodule

// File: rtl/sc_frame_tx.sv
module sc_frame_tx #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int SAMPLE_H = 21,
   parameter int TEND_N_H = 25,
   parameter int TEND_G_H = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              gsm_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [IDX_W-1:0]  half_idx_i,
   input  logic              half_end_i,
   input  logic              line_i,
   output logic              busy_o,
   output logic              tx_o,
   output logic              err_hit_o,
   output logic              tend_pt_o
);

   localparam int FB = sc_tx_pkg::frame_bits(DATA_W);

   logic          busy_q;
   logic [FB-1:0] frame_q;
   logic [IDX_W-1:0] bit_idx;
   logic          bit_val;
   logic [IDX_W-1:0] tend_last;

   assign bit_idx   = half_idx_i >> 1;
   assign tend_last = gsm_i ? IDX_W'(TEND_G_H - 1) : IDX_W'(TEND_N_H - 1);

   // select the current frame slot; slots past the parity bit are guard (high)
   always_comb begin
      bit_val = 1'b1;
      for (int k = 0; k < FB; k++) begin
         if (bit_idx == IDX_W'(k)) bit_val = frame_q[k];
      end
   end

   assign tx_o      = busy_q ? bit_val : 1'b1;
   assign busy_o    = busy_q;
   assign tend_pt_o = busy_q && half_end_i && (half_idx_i == tend_last);
   assign err_hit_o = busy_q && half_end_i && !line_i &&
                      (half_idx_i == IDX_W'(SAMPLE_H - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         frame_q <= '1;
      end else if (abort_i) begin
         busy_q  <= 1'b0;
      end else if (start_i) begin
         busy_q  <= 1'b1;
         frame_q <= {^data_i, data_i, 1'b0};
      end else if (tend_pt_o) begin
         busy_q  <= 1'b0;
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (half_idx_i < IDX_W'(2))) |-> !tx_o);

   // R2
   guard_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (half_idx_i >= IDX_W'(2 * FB))) |-> tx_o);

endmodule

// File: rtl/sc_card_clk.sv
module sc_card_clk #(
   parameter int CK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gsm_i,
   input  logic [1:0] ck_sel_i,
   output logic       card_clk_o
);

   import sc_tx_pkg::*;

   logic run_w;
   logic lvl_w;
   logic ck_q;

   // bit 0 runs the clock in both modes; a fixed high level exists only in GSM mode
   assign run_w      = ck_sel_i[0];
   assign lvl_w      = gsm_i & ck_sel_i[1];
   assign card_clk_o = ck_q;

   generate
      if (CK_HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ck_q <= 1'b0;
            else if (run_w) ck_q <= ~ck_q;
            else            ck_q <= lvl_w;
         end
      end else begin : g_div
         localparam int CW = $clog2(CK_HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               ck_q  <= 1'b0;
            end else if (!run_w) begin
               cnt_q <= '0;
               ck_q  <= lvl_w;
            end else if (cnt_q == CW'(CK_HALF - 1)) begin
               cnt_q <= '0;
               ck_q  <= ~ck_q;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   endgenerate

   // R12
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gsm_i && ck_sel_i == CKS_HIGH) |=> card_clk_o);

   // R11
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ck_sel_i[0] && (!gsm_i || ck_sel_i == CKS_LOW)) |=> !card_clk_o);

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
   parameter int DATA_W  = 8,
   parameter int LEN_W   = 12,
   parameter int CK_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_i,
   input  logic              tx_en_i,
   input  logic              gsm_i,
   input  logic [LEN_W-1:0]  half_len_i,
   input  logic              wr_cpu_i,
   input  logic              wr_dma_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              tdre_rd_i,
   input  logic              tdre_clr_i,
   input  logic              err_clr_i,
   input  logic              line_i,
   input  logic [1:0]        ck_sel_i,
   output logic              tx_o,
   output logic              card_clk_o,
   output logic              tdre_o,
   output logic              tend_o,
   output logic              err_o
);

   localparam int FB       = sc_tx_pkg::frame_bits(DATA_W);
   localparam int SAMPLE_H = 2 * FB + 1;
   localparam int TEND_N_H = 2 * FB + 5;
   localparam int TEND_G_H = 2 * FB + 2;
   localparam int IDX_W    = $clog2(TEND_N_H + 1);

   generate
      if (DATA_W < 1)  begin : g_bad_data  $error("DATA_W must be at least 1");  end
      if (LEN_W < 1)   begin : g_bad_len   $error("LEN_W must be at least 1");   end
      if (CK_HALF < 1) begin : g_bad_ck    $error("CK_HALF must be at least 1"); end
   endgenerate

   logic [DATA_W-1:0] buf_q;
   logic              tdre_q, tend_q, err_q, armed_q;
   logic              busy_w, start_w, abort_w, clr_eff_w;
   logic              err_hit_w, tend_pt_w, half_end_w;
   logic [IDX_W-1:0]  half_idx_w;

   assign abort_w   = !tx_en_i || standby_i;
   assign start_w   = tx_en_i && !standby_i && !tdre_q && !busy_w;
   assign clr_eff_w = tdre_clr_i && armed_q;

   sc_etu_timer #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .run_i      (busy_w),
      .half_len_i (half_len_i),
      .half_idx_o (half_idx_w),
      .half_end_o (half_end_w)
   );

   sc_frame_tx #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .SAMPLE_H (SAMPLE_H),
      .TEND_N_H (TEND_N_H),
      .TEND_G_H (TEND_G_H)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .abort_i    (abort_w),
      .gsm_i      (gsm_i),
      .data_i     (buf_q),
      .half_idx_i (half_idx_w),
      .half_end_i (half_end_w),
      .line_i     (line_i),
      .busy_o     (busy_w),
      .tx_o       (tx_o),
      .err_hit_o  (err_hit_w),
      .tend_pt_o  (tend_pt_w)
   );

   sc_card_clk #(.CK_HALF(CK_HALF)) u_ck (
      .clk        (clk),
      .rst_n      (rst_n),
      .gsm_i      (gsm_i),
      .ck_sel_i   (ck_sel_i),
      .card_clk_o (card_clk_o)
   );

   // holding buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    buf_q <= '0;
      else if (wr_cpu_i || wr_dma_i) buf_q <= wr_data_i;
   end

   // empty flag and the read-before-clear arming
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdre_q  <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         if (wr_dma_i || clr_eff_w) tdre_q <= 1'b0;
         else if (start_w)          tdre_q <= 1'b1;
         if (wr_dma_i || clr_eff_w)     armed_q <= 1'b0;
         else if (tdre_rd_i && tdre_q)  armed_q <= 1'b1;
      end
   end

   // end flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tend_q <= 1'b1;
      else if (standby_i || (!tx_en_i && !err_q)) tend_q <= 1'b1;
      else if (wr_dma_i || clr_eff_w)          tend_q <= 1'b0;
      else if (tend_pt_w && tdre_q && !err_q)  tend_q <= 1'b1;
   end

   // error flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_q <= 1'b0;
      else if (err_hit_w) err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
   end

   assign tdre_o = tdre_q;
   assign tend_o = tend_q;
   assign err_o  = err_q;

   // R6
   tend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend_q) |-> ($past(tdre_q && !err_q) || $past(!tx_en_i && !err_q) ||
                         $past(standby_i)));

   // R7
   tdre_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdre_q) |-> $past(wr_dma_i || (tdre_clr_i && armed_q)));

   // R9
   tend_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_i || (!tx_en_i && !err_q)) |=> tend_q);

   // R10
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(busy_w && !line_i));

endmodule

// File: tb/sc_char_tx_bench.sv
module sc_char_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby_i = 1'b0, tx_en_i = 1'b0, gsm_i = 1'b0;
   logic [11:0] half_len_i = 12'd2;
   logic       wr_cpu_i = 1'b0, wr_dma_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic       tdre_rd_i = 1'b0, tdre_clr_i = 1'b0, err_clr_i = 1'b0;
   logic       line_i = 1'b1;
   logic [1:0] ck_sel_i = 2'b00;
   logic       tx_o, card_clk_o, tdre_o, tend_o, err_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   sc_char_tx u_sc_char_tx (
      .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .tx_en_i(tx_en_i),
      .gsm_i(gsm_i), .half_len_i(half_len_i), .wr_cpu_i(wr_cpu_i),
      .wr_dma_i(wr_dma_i), .wr_data_i(wr_data_i), .tdre_rd_i(tdre_rd_i),
      .tdre_clr_i(tdre_clr_i), .err_clr_i(err_clr_i), .line_i(line_i),
      .ck_sel_i(ck_sel_i), .tx_o(tx_o), .card_clk_o(card_clk_o),
      .tdre_o(tdre_o), .tend_o(tend_o), .err_o(err_o)
   );

   // {inject error, gsm, data}
   localparam logic [9:0] VEC [6] = '{
      {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'h5A},
      {1'b1, 1'b1, 8'h80}, {1'b0, 1'b0, 8'h01}, {1'b0, 1'b1, 8'hFF}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cpu_load(input logic [7:0] d);
      wr_data_i = d; wr_cpu_i = 1'b1; tick(1); wr_cpu_i = 1'b0;
   endtask

   task automatic arm_clear();
      tdre_rd_i = 1'b1; tick(1); tdre_rd_i = 1'b0;
      tdre_clr_i = 1'b1; tick(1); tdre_clr_i = 1'b0;
   endtask

   task automatic wait_fall(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (!tx_o) begin ok = 1'b1; return; end
         tick(1);
      end
   endtask

   task automatic count_toggles(output int n);
      logic prev;
      n = 0;
      prev = card_clk_o;
      for (int i = 0; i < 16; i++) begin
         tick(1);
         if (card_clk_o != prev) n++;
         prev = card_clk_o;
      end
   endtask

   // one frame from the processor path; half_len_i = 2 so a bit is 4 cycles
   task automatic run_frame(input bit gsm, input logic [7:0] d, input bit inj);
      bit ok;
      int bad;
      int tend_t;
      logic [9:0] fr;
      gsm_i = gsm;
      cpu_load(d);
      arm_clear();
      wait_fall(ok);
      chk(ok, "R3 frame start", ok, 1);
      fr = {^d, d, 1'b0};
      tend_t = gsm ? 44 : 50;
      bad = 0;
      for (int t = 0; t <= tend_t; t++) begin
         if (t == 0) chk(tdre_o == 1'b1, "R3 empty flag set at start", tdre_o, 1);
         if ((t % 4 == 2) && (t / 4 < 10) && (tx_o !== fr[t / 4])) bad++;
         if (t == tend_t - 1)
            chk(tend_o == 1'b0, gsm ? "R5 end flag early" : "R4 end flag early", tend_o, 0);
         if (t == tend_t)
            chk(tend_o == !inj, inj ? "R6 end flag with error" :
                (gsm ? "R5 end flag point" : "R4 end flag point"), tend_o, !inj);
         if (inj && t == 40) line_i = 1'b0;
         if (inj && t == 44) line_i = 1'b1;
         if (t < tend_t) tick(1);
      end
      chk(bad == 0, "R2 frame bits", bad, 0);
      if (inj) begin
         chk(err_o == 1'b1, "R10 error flag set", err_o, 1);
         tick(3);
         chk(err_o == 1'b1, "R10 error flag held", err_o, 1);
         err_clr_i = 1'b1; tick(1); err_clr_i = 1'b0;
         chk(err_o == 1'b0, "R10 error flag cleared", err_o, 0);
      end
      tick(2);
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit ok;
      int n;
      int bad;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1
      chk(tx_o == 1'b1, "R1 line idle", tx_o, 1);
      chk(tdre_o == 1'b1, "R1 empty flag", tdre_o, 1);
      chk(tend_o == 1'b1, "R1 end flag", tend_o, 1);
      chk(err_o == 1'b0, "R1 error flag", err_o, 0);
      chk(card_clk_o == 1'b0, "R1 card clock", card_clk_o, 0);

      tx_en_i = 1'b1;
      tick(2);
      for (int v = 0; v < 6; v++) run_frame(VEC[v][8], VEC[v][7:0], VEC[v][9]);

      // R7: clear with no prior read
      gsm_i = 1'b0;
      tdre_clr_i = 1'b1; tick(1); tdre_clr_i = 1'b0;
      chk(tdre_o == 1'b1, "R7 clear without read keeps empty", tdre_o, 1);
      chk(tend_o == 1'b1, "R7 clear without read keeps end", tend_o, 1);
      arm_clear();
      chk(tdre_o == 1'b0, "R7 read then clear empties", tdre_o, 0);
      chk(tend_o == 1'b0, "R7 read then clear ends", tend_o, 0);
      tick(60);

      // R8: DMA load, then a second DMA load mid-frame
      wr_data_i = 8'h96; wr_dma_i = 1'b1; tick(1); wr_dma_i = 1'b0;
      chk(tdre_o == 1'b0, "R8 DMA clears empty", tdre_o, 0);
      chk(tend_o == 1'b0, "R8 DMA clears end", tend_o, 0);
      wait_fall(ok);
      chk(ok, "R8 DMA frame start", ok, 1);
      bad = 0;
      for (int t = 0; t <= 52; t++) begin
         if ((t % 4 == 2) && (t / 4 < 10) && (tx_o !== ({^8'h96, 8'h96, 1'b0} >> (t / 4)) % 2)) bad++;
         if (t == 10) begin wr_data_i = 8'h11; wr_dma_i = 1'b1; end
         if (t == 11) wr_dma_i = 1'b0;
         if (t == 50) chk(tend_o == 1'b0, "R6 end flag held with buffer full", tend_o, 0);
         if (t == 52) chk(tx_o == 1'b0, "R3 back-to-back start", tx_o, 0);
         if (t < 52) tick(1);
      end
      chk(bad == 0, "R8 DMA data sent", bad, 0);
      tick(60);
      chk(tend_o == 1'b1, "R4 end after second frame", tend_o, 1);

      // R9: transmit disable mid-frame
      cpu_load(8'h0F);
      arm_clear();
      wait_fall(ok);
      tick(10);
      tx_en_i = 1'b0; tick(1);
      chk(tend_o == 1'b1, "R9 disable forces end", tend_o, 1);
      chk(tx_o == 1'b1, "R9 disable abandons frame", tx_o, 1);
      tx_en_i = 1'b1; tick(2);

      // R9: standby mid-frame
      cpu_load(8'hC3);
      arm_clear();
      wait_fall(ok);
      tick(10);
      standby_i = 1'b1; tick(1); standby_i = 1'b0;
      chk(tend_o == 1'b1, "R9 standby forces end", tend_o, 1);
      chk(tx_o == 1'b1, "R9 standby abandons frame", tx_o, 1);
      tick(2);

      // card clock
      gsm_i = 1'b0; ck_sel_i = 2'b01; tick(3);
      count_toggles(n);
      chk(n == 8, "R13 toggle rate", n, 8);
      gsm_i = 1'b0; ck_sel_i = 2'b10; tick(3);
      count_toggles(n);
      chk(n == 0 && card_clk_o == 1'b0, "R11 normal mode 10 holds low", card_clk_o, 0);
      gsm_i = 1'b0; ck_sel_i = 2'b11; tick(3);
      count_toggles(n);
      chk(n == 8, "R11 normal mode 11 runs", n, 8);
      gsm_i = 1'b1; ck_sel_i = 2'b10; tick(3);
      count_toggles(n);
      chk(n == 0 && card_clk_o == 1'b1, "R12 GSM 10 holds high", card_clk_o, 1);
      gsm_i = 1'b1; ck_sel_i = 2'b00; tick(3);
      count_toggles(n);
      chk(n == 0 && card_clk_o == 1'b0, "R12 GSM 00 holds low", card_clk_o, 0);
      gsm_i = 1'b1; ck_sel_i = 2'b11; tick(3);
      count_toggles(n);
      chk(n == 8, "R12 GSM 11 runs", n, 8);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule